// File: doc/BRIEF.md
# Star Hub Message Router

This block is the centre of a star network. It has one local core port and up to eight leaf nodes. Each leaf connects to it through two one-way 32-bit streaming channels, one inbound and one outbound. Every message in the network passes through the hub. A message is four words long. Word 0 holds the sender id and word 1 holds the target id, and both come before two payload words. The hub has id 0. The leaf on channel index `i` has id `i+1`.

The hub takes one complete message at a time from its inbound channels, serving them in rotating order. It stores the message and then reads the target id. If the target is another leaf, the four words go out on that leaf's outbound channel. If the target is the hub, the words go into a local word buffer that the core drains later. If the target id is not a node, the message is dropped and a sticky error flag is raised. Deliveries to the hub from each inbound channel mark a pending bit, and an enable mask combines these bits into the core's single interrupt request.

Top module: `star_hub_router`

## Requirements
- R1: While reset is high and in the cycle after it, every `out_valid` bit, `loc_valid`, every `pending` bit, `irq` and `err_flag` are 0.
- R2: A message with target id `d` in 1..LEAVES leaves on outbound channel `d-1`, with all four words unchanged and in order.
- R3: A message with target id 0 is written into the local buffer. The core reads its four words in order through `loc_valid`/`loc_data`/`loc_pop`.
- R4: When the last word of a message addressed to the hub is stored, the pending bit of the inbound channel it came from is set. No other bit changes, and forwarded or dropped messages set no bit.
- R5: `irq` is 1 exactly when some pending bit is set and its `irq_en` bit is also 1.
- R6: A 1 on bit `i` of `pend_clr` clears pending bit `i` at the next edge and leaves the other bits as they were. A set and a clear of the same bit in the same cycle leaves the bit set.
- R7: A message whose target id (the whole 32-bit word 1) is greater than LEAVES is still taken in full, but nothing is emitted on any outbound channel or into the local buffer, and `err_flag` goes to 1 and stays 1 until reset.
- R8: When several inbound channels hold a message, they are served one whole message at a time. The channel served next is the first requester found after the most recently served channel, counting upward and wrapping. After reset the search starts at channel 0.
- R9: At any time at most one `in_ready` bit and at most one `out_valid` bit is high.
- R10: An outbound word that is not accepted keeps its `out_valid` high and its data unchanged until `out_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | LEAVES | Inbound word valid, one bit per leaf |
| in_data | input | LEAVES*32 | Inbound words; channel i uses bits [32i+31:32i] |
| in_ready | output | LEAVES | Hub accepts the inbound word on that channel |
| out_valid | output | LEAVES | Outbound word valid, one bit per leaf |
| out_data | output | LEAVES*32 | Outbound words; channel i uses bits [32i+31:32i] |
| out_ready | input | LEAVES | Leaf accepts the outbound word |
| loc_valid | output | 1 | Local buffer holds at least one word |
| loc_data | output | 32 | Oldest word in the local buffer |
| loc_pop | input | 1 | Core takes `loc_data` |
| irq_en | input | LEAVES | Interrupt enable per inbound channel |
| pend_clr | input | LEAVES | Write-one-to-clear strobe for pending bits |
| pending | output | LEAVES | Pending delivery bit per inbound channel |
| irq | output | 1 | Combined interrupt request |
| err_flag | output | 1 | Sticky bad-target flag |

## Verification
From an idle hub, the first `in_ready` of a chosen leaf rises one cycle after its `in_valid` is seen. After that, one word is taken per cycle. The first outbound word or local write comes in the cycle after the fourth inbound word is taken. `err_flag` rises at that same edge. A pending bit is visible right after the edge that stores the fourth local word, and `irq` follows it combinationally. A clear shows one edge after the strobe. The bench drives inputs on falling edges and reads every result on a falling edge. It waits on handshake signals with bounded loops instead of assuming fixed latencies, so each check falls after the edge that produces the value.

// File: rtl/hub_pkg.sv
package hub_pkg;
    localparam int WORD_W  = 32;
    localparam int MSG_LEN = 4;
    localparam int POS_SRC = 0;
    localparam int POS_DST = 1;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        HUB_IDLE,
        HUB_COLLECT,
        HUB_SEND
    } hub_state_e;

    typedef struct packed {
        logic known;
        logic to_hub;
    } route_t;

    function automatic route_t classify(input word_t dst, input int unsigned leaves);
        route_t r;
        r.known  = (dst <= word_t'(leaves));
        r.to_hub = (dst == '0);
        return r;
    endfunction
endpackage

// File: rtl/hub_rr_pick.sv
module hub_rr_pick #(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          take,
    output logic [IW-1:0] pick,
    output logic          any
);
    logic [IW-1:0] last_q;

    always_comb begin
        any  = 1'b0;
        pick = last_q;
        for (int k = 1; k <= N; k++) begin
            int cand;
            cand = int'(last_q) + k;
            if (cand >= N) cand = cand - N;
            if (!any && req[cand]) begin
                any  = 1'b1;
                pick = IW'(cand);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)             last_q <= IW'(N - 1);
        else if (take && any) last_q <= pick;
    end
endmodule

// File: rtl/hub_word_fifo.sv
module hub_word_fifo
    import hub_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  word_t wdata,
    output logic  full,
    input  logic  pop,
    output word_t rdata,
    output logic  valid
);
    word_t       mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [AW:0]   cnt_q;
    logic          do_push, do_pop;

    assign full    = (cnt_q == (AW+1)'(DEPTH));
    assign valid   = (cnt_q != '0);
    assign rdata   = mem[rd_q];
    assign do_push = push && !full;
    assign do_pop  = pop && valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= wr_q + 1'b1;
            if (do_pop)  rd_q <= rd_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= wdata;
    end
endmodule

// File: rtl/hub_irq_merge.sv
module hub_irq_merge #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    input  logic [N-1:0] en,
    output logic [N-1:0] pending,
    output logic         irq
);
    always_ff @(posedge clk) begin
        if (rst) pending <= '0;
        else     pending <= (pending & ~clr_vec) | set_vec;
    end

    assign irq = |(pending & en);
endmodule

// File: rtl/star_hub_router.sv
module star_hub_router
    import hub_pkg::*;
#(
    parameter int LEAVES      = 8,
    parameter int LOCAL_WORDS = 16,
    localparam int IW = $clog2(LEAVES),
    localparam int CW = $clog2(MSG_LEN)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [LEAVES-1:0]        in_valid,
    input  logic [LEAVES*WORD_W-1:0] in_data,
    output logic [LEAVES-1:0]        in_ready,
    output logic [LEAVES-1:0]        out_valid,
    output logic [LEAVES*WORD_W-1:0] out_data,
    input  logic [LEAVES-1:0]        out_ready,
    output logic                     loc_valid,
    output logic [WORD_W-1:0]        loc_data,
    input  logic                     loc_pop,
    input  logic [LEAVES-1:0]        irq_en,
    input  logic [LEAVES-1:0]        pend_clr,
    output logic [LEAVES-1:0]        pending,
    output logic                     irq,
    output logic                     err_flag
);
    hub_state_e    state_q;
    logic [IW-1:0] sel_q, dst_ch_q, pick;
    logic [CW-1:0] wcnt_q;
    logic          to_hub_q, any_req, take;
    word_t         msg_q [MSG_LEN];
    word_t         in_word, cur_word;
    logic          fifo_full, fifo_push, fwd_take, word_sent, last_word;
    logic [LEAVES-1:0] set_vec;
    route_t        route;

    assign take      = (state_q == HUB_IDLE);
    assign in_word   = in_data[sel_q*WORD_W +: WORD_W];
    assign cur_word  = msg_q[wcnt_q];
    assign last_word = (wcnt_q == CW'(MSG_LEN - 1));
    assign route     = classify(msg_q[POS_DST], LEAVES);

    hub_rr_pick #(.N(LEAVES)) u_pick (
        .clk(clk), .rst(rst), .req(in_valid), .take(take),
        .pick(pick), .any(any_req)
    );

    for (genvar i = 0; i < LEAVES; i++) begin : g_lane
        assign in_ready[i]  = (state_q == HUB_COLLECT) && (sel_q == IW'(i));
        assign out_valid[i] = (state_q == HUB_SEND) && !to_hub_q && (dst_ch_q == IW'(i));
        assign out_data[i*WORD_W +: WORD_W] = cur_word;
        assign set_vec[i]   = fifo_push && last_word && (sel_q == IW'(i));
    end

    assign fifo_push = (state_q == HUB_SEND) && to_hub_q && !fifo_full;
    assign fwd_take  = (state_q == HUB_SEND) && !to_hub_q && out_ready[dst_ch_q];
    assign word_sent = fifo_push || fwd_take;

    hub_word_fifo #(.DEPTH(LOCAL_WORDS)) u_local (
        .clk(clk), .rst(rst), .push(fifo_push), .wdata(cur_word),
        .full(fifo_full), .pop(loc_pop), .rdata(loc_data), .valid(loc_valid)
    );

    hub_irq_merge #(.N(LEAVES)) u_irq (
        .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(pend_clr),
        .en(irq_en), .pending(pending), .irq(irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= HUB_IDLE;
            sel_q    <= '0;
            wcnt_q   <= '0;
            to_hub_q <= 1'b0;
            dst_ch_q <= '0;
            err_flag <= 1'b0;
        end else begin
            case (state_q)
                HUB_IDLE: begin
                    if (any_req) begin
                        sel_q   <= pick;
                        wcnt_q  <= '0;
                        state_q <= HUB_COLLECT;
                    end
                end
                HUB_COLLECT: begin
                    if (in_valid[sel_q]) begin
                        wcnt_q <= wcnt_q + 1'b1;
                        if (last_word) begin
                            wcnt_q <= '0;
                            if (!route.known) begin
                                err_flag <= 1'b1;
                                state_q  <= HUB_IDLE;
                            end else begin
                                to_hub_q <= route.to_hub;
                                dst_ch_q <= IW'(msg_q[POS_DST] - word_t'(1));
                                state_q  <= HUB_SEND;
                            end
                        end
                    end
                end
                HUB_SEND: begin
                    if (word_sent) begin
                        wcnt_q <= wcnt_q + 1'b1;
                        if (last_word) state_q <= HUB_IDLE;
                    end
                end
                default: state_q <= HUB_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (state_q == HUB_COLLECT && in_valid[sel_q]) msg_q[wcnt_q] <= in_word;
    end
endmodule

// File: rtl/hub_router_chk.sv
module hub_router_chk
    import hub_pkg::*;
#(
    parameter int LEAVES = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic [LEAVES-1:0]        in_ready,
    input logic [LEAVES-1:0]        out_valid,
    input logic [LEAVES*WORD_W-1:0] out_data,
    input logic [LEAVES-1:0]        out_ready,
    input logic                     loc_valid,
    input logic [LEAVES-1:0]        irq_en,
    input logic [LEAVES-1:0]        pending,
    input logic                     irq,
    input logic                     err_flag
);
    a_r9_one_inbound: assert property (@(posedge clk) disable iff (rst)
        $onehot0(in_ready));

    a_r9_one_outbound: assert property (@(posedge clk) disable iff (rst)
        $onehot0(out_valid));

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);

    a_r5_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        ((pending & irq_en) == '0) |-> !irq);

    for (genvar i = 0; i < LEAVES; i++) begin : g_chk
        a_r10_hold: assert property (@(posedge clk) disable iff (rst)
            (out_valid[i] && !out_ready[i]) |=>
                (out_valid[i] && $stable(out_data[i*WORD_W +: WORD_W])));

        a_r4_rise_with_data: assert property (@(posedge clk) disable iff (rst)
            (!$past(pending[i]) && pending[i]) |-> loc_valid);
    end
endmodule

bind star_hub_router hub_router_chk #(.LEAVES(LEAVES)) u_chk (
    .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready), .loc_valid(loc_valid),
    .irq_en(irq_en), .pending(pending), .irq(irq), .err_flag(err_flag)
);

// File: tb/star_hub_router_tb.sv
module star_hub_router_tb;
    localparam int L = 8;
    localparam int W = 32;

    logic           clk = 1'b0;
    logic           rst;
    logic [L-1:0]   in_valid;
    logic [L*W-1:0] in_data;
    logic [L-1:0]   in_ready;
    logic [L-1:0]   out_valid;
    logic [L*W-1:0] out_data;
    logic [L-1:0]   out_ready;
    logic           loc_valid;
    logic [W-1:0]   loc_data;
    logic           loc_pop;
    logic [L-1:0]   irq_en;
    logic [L-1:0]   pend_clr;
    logic [L-1:0]   pending;
    logic           irq;
    logic           err_flag;

    int checks = 0;
    int fails  = 0;
    int last_ch;
    bit done = 0;

    always #10 clk = ~clk;

    star_hub_router #(.LEAVES(L), .LOCAL_WORDS(16)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready), .loc_valid(loc_valid), .loc_data(loc_data),
        .loc_pop(loc_pop), .irq_en(irq_en), .pend_clr(pend_clr),
        .pending(pending), .irq(irq), .err_flag(err_flag)
    );

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] mk(input int ch, input int dst, input int w);
        case (w)
            0:       return W'(ch + 1);
            1:       return W'(dst);
            2:       return 32'hA000_0000 | W'(ch << 12) | W'(dst);
            default: return ~(32'hA000_0000 | W'(ch << 12) | W'(dst));
        endcase
    endfunction

    task automatic send_msg(input int ch, input int dst);
        for (int w = 0; w < 4; w++) begin
            in_valid[ch] = 1'b1;
            in_data[ch*W +: W] = mk(ch, dst, w);
            while (!in_ready[ch]) @(negedge clk);
            @(negedge clk);
        end
        in_valid[ch] = 1'b0;
    endtask

    task automatic recv_out(input int och, input int src, input int dst);
        for (int w = 0; w < 4; w++) begin
            while (!out_valid[och]) @(negedge clk);
            chk(out_data[och*W +: W] == mk(src, dst, w), "R2 forwarded word",
                out_data[och*W +: W], mk(src, dst, w));
            @(negedge clk);
        end
    endtask

    task automatic pop_local(input int src);
        loc_pop = 1'b1;
        for (int w = 0; w < 4; w++) begin
            while (!loc_valid) @(negedge clk);
            chk(loc_data == mk(src, 0, w), "R3 local word", loc_data, mk(src, 0, w));
            @(negedge clk);
        end
        loc_pop = 1'b0;
    endtask

    task automatic wait_pend(input logic [L-1:0] bits);
        for (int k = 0; k < 40; k++) begin
            if ((pending & bits) == bits) break;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst = 1'b1; in_valid = '0; in_data = '0; out_ready = '1;
        loc_pop = 1'b0; irq_en = '1; pend_clr = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(out_valid == '0 && !loc_valid, "R1 outputs idle", {out_valid, 7'd0, loc_valid}, '0);
        chk(pending == '0 && !irq && !err_flag, "R1 status clear", {pending, irq, err_flag}, '0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == '0 && pending == '0 && !err_flag, "R1 after release", {out_valid, pending}, '0);
        last_ch = L - 1;

        // Sweep every source channel against every target id 0..L+1
        for (int s = 0; s < L; s++) begin
            for (int d = 0; d <= L + 1; d++) begin
                if (d == 0) begin
                    send_msg(s, 0);
                    wait_pend(L'(1) << s);
                    chk(pending == (L'(1) << s), "R4 pending bit", W'(pending), W'(L'(1) << s));
                    chk(irq, "R5 irq enabled", W'(irq), 1);
                    irq_en = ~(L'(1) << s);
                    #1;
                    chk(!irq, "R5 irq masked", W'(irq), 0);
                    irq_en = '1;
                    pop_local(s);
                    pend_clr = L'(1) << s;
                    @(negedge clk);
                    pend_clr = '0;
                    chk(pending == '0, "R6 write-one clear", W'(pending), 0);
                    chk(!irq, "R5 irq drops", W'(irq), 0);
                end else if (d <= L) begin
                    fork
                        send_msg(s, d);
                        recv_out(d - 1, s, d);
                    join
                    chk(pending == '0, "R4 forward sets nothing", W'(pending), 0);
                end else begin
                    send_msg(s, d);
                    repeat (3) @(negedge clk);
                    chk(err_flag, "R7 err set", W'(err_flag), 1);
                    chk(out_valid == '0 && !loc_valid, "R7 nothing emitted",
                        {out_valid, 7'd0, loc_valid}, 0);
                end
                last_ch = s;
            end
        end

        // R7: very large target id, flag stays
        send_msg(2, 256);
        repeat (3) @(negedge clk);
        chk(err_flag && out_valid == '0 && !loc_valid, "R7 large id dropped",
            {err_flag, out_valid, loc_valid}, 32'h200);
        last_ch = 2;

        // R10: backpressure on outbound channel 4
        out_ready[4] = 1'b0;
        send_msg(1, 5);
        repeat (2) @(negedge clk);
        chk(out_valid[4] && out_data[4*W +: W] == mk(1, 5, 0), "R10 held word",
            out_data[4*W +: W], mk(1, 5, 0));
        repeat (4) @(negedge clk);
        chk(out_valid[4] && out_data[4*W +: W] == mk(1, 5, 0), "R10 still held",
            out_data[4*W +: W], mk(1, 5, 0));
        out_ready[4] = 1'b1;
        recv_out(4, 1, 5);
        last_ch = 1;

        // R8: three simultaneous senders to the hub
        fork
            send_msg(0, 0);
            send_msg(3, 0);
            send_msg(6, 0);
        join
        wait_pend(8'b0100_1001);
        chk(pending == 8'b0100_1001, "R4 three pending", W'(pending), 32'h49);
        pend_clr = 8'b0000_1000;
        @(negedge clk);
        pend_clr = '0;
        chk(pending == 8'b0100_0001, "R6 partial clear", W'(pending), 32'h41);
        chk(irq, "R5 irq remains", W'(irq), 1);
        for (int k = 1; k <= L; k++) begin
            int c;
            c = (last_ch + k) % L;
            if (c == 0 || c == 3 || c == 6) begin
                loc_pop = 1'b1;
                while (!loc_valid) @(negedge clk);
                chk(loc_data == W'(c + 1), "R8 service order", loc_data, W'(c + 1));
                loc_pop = 1'b0;
                pop_local(c);
            end
        end
        pend_clr = '1;
        @(negedge clk);
        pend_clr = '0;
        chk(pending == '0 && !irq, "R6 all cleared", W'(pending), 0);

        finish_run();
    end
endmodule